// File: doc/BRIEF.md
# Pipeline Latency Data Checker

This block is a synthesizable monitor that sits beside a datapath with a fixed latency. It watches the words going into the datapath and the words coming out. It flags any output word that differs from the input word seen a set number of beats earlier. It drives no part of the datapath. It only reports.

The block has two modes, selected by `mode_sel`.

- **Free-running mode (`mode_sel` = 0):** every clock is a beat. The history of input words advances each cycle, and every output cycle is compared.
- **Valid-qualified mode (`mode_sel` = 1):** only input cycles with `vld_in` high enter the history. Only output cycles with `vld_out` high are compared.

After reset, comparisons are held off until the history is full, so a stale history word can never cause a false mismatch. In valid-qualified mode, an output beat that arrives before the history is full is reported on its own underflow line. A mismatch pulse appears in the same cycle as the bad output word, which points to the exact failing beat. A sticky flag collects every error until the next reset.

Top module: `pipe_latency_checker`

## Requirements
- R1: In free-running mode with the history full, `err_mismatch` is high in cycle k exactly when `dout` in cycle k differs from `din` in cycle k-LAT (LAT defaults to 3). `vld_in` and `vld_out` have no effect in this mode.
- R2: In valid-qualified mode with the history full, the reference word is the LAT-th most recent `din` accepted with `vld_in` high in an earlier cycle. A valid input in the current cycle does not count toward the current compare.
- R3: No mismatch is reported while the history is filling. In free-running mode this covers the first LAT cycles after reset is released. In valid-qualified mode it lasts until LAT valid inputs have been recorded.
- R4: `err_mismatch` is combinational and high only in the cycle of the mismatching output beat. Each bad beat produces a pulse one cycle long.
- R5: In valid-qualified mode, a cycle with `vld_out` low raises neither error, whatever `dout` holds.
- R6: In valid-qualified mode, `vld_out` high before LAT valid inputs have been recorded raises `err_underflow` in that cycle, and `err_mismatch` stays low in that cycle. `err_underflow` never rises in free-running mode.
- R7: While `rst_n` is low, all outputs are 0. `err_sticky` rises the cycle after any error pulse and holds until reset.
- R8: `mode_sel` (0 = free-running, 1 = valid-qualified) is captured only while `rst_n` is low. Changing it after reset is released has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | 0 = free-running, 1 = valid-qualified; captured during reset |
| din | input | W | Word entering the datapath under check |
| vld_in | input | 1 | Input beat valid (valid-qualified mode) |
| dout | input | W | Word leaving the datapath under check |
| vld_out | input | 1 | Output beat valid (valid-qualified mode) |
| err_mismatch | output | 1 | One-cycle pulse on a bad output beat |
| err_underflow | output | 1 | Pulse when an output beat arrives before the history is full |
| err_sticky | output | 1 | Set by any error pulse, cleared only by reset |

## Verification
The bench drives junk output words during the warm-up cycles. A checker that compares against an unfilled history would pulse `err_mismatch` there.

In valid-qualified mode, the bench spaces valid inputs with random gaps and sends junk on cycles with `vld_out` low. This exposes three faults:
- a history that advances every clock, which would pick the wrong reference;
- a checker that ignores `vld_out`, which would flag idle cycles;
- a warm-up that counts clocks instead of valid beats, which would miss the underflow beats.

The bench also changes `mode_sel` while the block is running, to catch a design that follows the live pin. It checks that the sticky flag survives later clean traffic and clears only on reset.

// File: rtl/lat_chk_pkg.sv
// Shared types for the pipeline latency data checker.
// Assumes nothing beyond a 1-bit mode encoding.
package lat_chk_pkg;

    // Operating mode; the encoding matches the mode_sel pin.
    typedef enum logic {
        CHK_FREE  = 1'b0,
        CHK_GATED = 1'b1
    } chk_mode_e;

endpackage

// File: rtl/lc_warmup.sv
// Saturating fill counter. It counts step pulses from 0 up to LAT and then
// holds. hist_full tells the compare stage that LAT words have entered the
// history. Assumes a synchronous active-low reset.
module lc_warmup #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic hist_full
);
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] FILL_MAX = CW'(LAT);

    logic [CW-1:0] fill_cnt;

    // Count accepted history steps and stop at LAT.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
        end else if (step && (fill_cnt != FILL_MAX)) begin
            fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // The history holds LAT words once the counter saturates.
    always_comb hist_full = (fill_cnt == FILL_MAX);

endmodule

// File: rtl/lc_history.sv
// Shift register of LAT words. A word enters stage 0 on every shift pulse.
// ref_word is the oldest stage, i.e. the LAT-th most recent word shifted in.
// Assumes the caller decides when a shift happens: every clock, or only on
// valid beats.
module lc_history #(
    parameter int W   = 8,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] ref_word
);
    genvar g;
    generate
        for (g = 0; g < LAT; g++) begin : g_stage
            logic [W-1:0] q;
            if (g == 0) begin : g_head
                // The first stage captures the incoming word.
                always_ff @(posedge clk) begin
                    if (!rst_n)     q <= '0;
                    else if (shift) q <= word_in;
                end
            end else begin : g_body
                // Each later stage takes the word held by the stage before it.
                always_ff @(posedge clk) begin
                    if (!rst_n)     q <= '0;
                    else if (shift) q <= g_stage[g-1].q;
                end
            end
        end
    endgenerate

    // The oldest word is the reference for the current output beat.
    always_comb ref_word = g_stage[LAT-1].q;

endmodule

// File: rtl/lc_compare.sv
// Combinational compare stage. It decides in the current cycle whether the
// output beat is wrong or arrived too early. Assumes ref_word and hist_full
// are registered values that reflect only cycles before this one.
module lc_compare
    import lat_chk_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         active,
    input  chk_mode_e    mode,
    input  logic         hist_full,
    input  logic         vld_out,
    input  logic [W-1:0] dout,
    input  logic [W-1:0] ref_word,
    output logic         mismatch,
    output logic         underflow
);
    logic beat;

    // An output beat is every cycle in free mode and a vld_out cycle in gated mode.
    always_comb beat = active && ((mode == CHK_FREE) || vld_out);

    // Compare only with a full history; an early beat in gated mode is an underflow.
    always_comb begin
        mismatch  = beat && hist_full && (dout != ref_word);
        underflow = beat && !hist_full && (mode == CHK_GATED);
    end

endmodule

// File: rtl/pipe_latency_checker.sv
// Top of the pipeline latency data checker. It captures the mode during
// reset, decides when the history advances, and keeps the sticky flag.
// Assumes mode_sel changes only while rst_n is low and that reset is
// synchronous and active low. The datapath under check is external.
module pipe_latency_checker
    import lat_chk_pkg::*;
#(
    parameter int W   = 8,
    parameter int LAT = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_sel,
    input  logic [W-1:0] din,
    input  logic         vld_in,
    input  logic [W-1:0] dout,
    input  logic         vld_out,
    output logic         err_mismatch,
    output logic         err_underflow,
    output logic         err_sticky
);
    chk_mode_e    mode_q;
    logic         hist_step;
    logic         hist_full;
    logic [W-1:0] ref_word;
    logic         mis_raw;
    logic         unf_raw;

    // Capture the mode only while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= chk_mode_e'(mode_sel);
    end

    // The history advances every clock in free mode and on valid inputs in gated mode.
    always_comb hist_step = (mode_q == CHK_FREE) || vld_in;

    lc_warmup #(.LAT(LAT)) u_warmup (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (hist_step),
        .hist_full (hist_full)
    );

    lc_history #(.W(W), .LAT(LAT)) u_history (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift    (hist_step),
        .word_in  (din),
        .ref_word (ref_word)
    );

    lc_compare #(.W(W)) u_compare (
        .active    (rst_n),
        .mode      (mode_q),
        .hist_full (hist_full),
        .vld_out   (vld_out),
        .dout      (dout),
        .ref_word  (ref_word),
        .mismatch  (mis_raw),
        .underflow (unf_raw)
    );

    // Drive the error pulses straight from the compare stage, in the cycle of the beat.
    always_comb begin
        err_mismatch  = mis_raw;
        err_underflow = unf_raw;
    end

    // The sticky flag collects every error pulse until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                   err_sticky <= 1'b0;
        else if (mis_raw || unf_raw)  err_sticky <= 1'b1;
    end

endmodule

// File: rtl/lat_chk_sva.sv
// Assertion checker for pipe_latency_checker, attached with bind. It keeps
// its own mode capture and fill count, built from the ports, to judge the
// warm-up window and the mode rules.
module lat_chk_sva #(
    parameter int LAT = 3
) (
    input logic clk,
    input logic rst_n,
    input logic mode_sel,
    input logic vld_in,
    input logic vld_out,
    input logic err_mismatch,
    input logic err_underflow,
    input logic err_sticky
);
    localparam int CW = $clog2(LAT + 1);
    localparam logic [CW-1:0] FILL_MAX = CW'(LAT);

    logic          sva_gated;
    logic [CW-1:0] sva_fill;

    // Record the mode the way the ports present it during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sva_gated <= mode_sel;
    end

    // Count history steps seen at the ports, saturating at LAT.
    always_ff @(posedge clk) begin
        if (!rst_n) sva_fill <= '0;
        else if ((!sva_gated || vld_in) && (sva_fill != FILL_MAX)) sva_fill <= sva_fill + 1'b1;
    end

    AST_NO_MISMATCH_IN_WARMUP: assert property (@(posedge clk) disable iff (!rst_n)
        (sva_fill != FILL_MAX) |-> !err_mismatch);                            // R3
    AST_IDLE_BEAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sva_gated && !vld_out) |-> (!err_mismatch && !err_underflow));      // R5
    AST_UNDERFLOW_GATED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |-> (sva_gated && vld_out && sva_fill != FILL_MAX));   // R6
    AST_ONE_ERROR_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_mismatch && err_underflow));                                    // R6
    AST_STICKY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mismatch || err_underflow) |=> err_sticky);                      // R7
    AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);                                           // R7
    AST_STICKY_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_sticky) |-> $past(err_mismatch || err_underflow));          // R7
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !sva_gated |-> !err_underflow);                                       // R8

endmodule

bind pipe_latency_checker lat_chk_sva #(.LAT(LAT)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_sel      (mode_sel),
    .vld_in        (vld_in),
    .vld_out       (vld_out),
    .err_mismatch  (err_mismatch),
    .err_underflow (err_underflow),
    .err_sticky    (err_sticky)
);

// File: tb/pipe_latency_checker_bench.sv
`timescale 1ns/1ps
module pipe_latency_checker_bench;
    localparam int W   = 8;
    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_sel = 1'b0;
    logic [W-1:0] din = '0;
    logic         vld_in = 1'b0;
    logic [W-1:0] dout = '0;
    logic         vld_out = 1'b0;
    logic         err_mismatch;
    logic         err_underflow;
    logic         err_sticky;

    always #2 clk = ~clk;   // 250 MHz

    pipe_latency_checker #(.W(W), .LAT(LAT)) u_pipe_latency_checker (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .din(din), .vld_in(vld_in),
        .dout(dout), .vld_out(vld_out), .err_mismatch(err_mismatch),
        .err_underflow(err_underflow), .err_sticky(err_sticky)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference model state, written from the requirements.
    logic [W-1:0] mh [LAT];
    int  mfill = 0;
    bit  msticky = 0;
    bit  mgated = 0;

    task automatic check(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic exp_mismatch();
        if (!rst_n) return 1'b0;
        if (mgated && !vld_out) return 1'b0;
        return (mfill == LAT) && (dout != mh[LAT-1]);
    endfunction

    function automatic logic exp_underflow();
        return rst_n && mgated && vld_out && (mfill < LAT);
    endfunction

    // Output word: the expected reference, or a corrupted copy of it.
    function automatic logic [W-1:0] pick_dout(bit corrupt);
        logic [W-1:0] flip;
        flip = W'($urandom_range(1, (1 << W) - 1));
        return corrupt ? (mh[LAT-1] ^ flip) : mh[LAT-1];
    endfunction

    // Drive one cycle, check the outputs before the edge, then advance the model.
    task automatic step(string tag, logic rn, logic md, logic [W-1:0] di,
                        logic vi, logic [W-1:0] dq, logic vo);
        logic em, eu;
        @(negedge clk);
        rst_n = rn; mode_sel = md; din = di; vld_in = vi; dout = dq; vld_out = vo;
        #1;
        em = exp_mismatch();
        eu = exp_underflow();
        check(tag, "err_mismatch", err_mismatch, em);
        check(tag, "err_underflow", err_underflow, eu);
        check("R7", "err_sticky", err_sticky, msticky);
        if (!rn) begin
            mfill = 0; msticky = 0; mgated = md;
            for (int i = 0; i < LAT; i++) mh[i] = '0;
        end else begin
            if (!mgated || vi) begin
                for (int i = LAT - 1; i > 0; i--) mh[i] = mh[i-1];
                mh[0] = di;
                if (mfill < LAT) mfill++;
            end
            if (em || eu) msticky = 1;
        end
    endtask

    task automatic do_reset(bit md);
        step("R7", 1'b0, md, '0, 1'b0, '0, 1'b0);
        step("R7", 1'b0, md, '0, 1'b0, '0, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < LAT; i++) mh[i] = '0;

        // R7: reset state, then free-running mode.
        do_reset(1'b0);
        // R3: junk output during the first LAT cycles must not be flagged.
        for (int i = 0; i < LAT; i++)
            step("R3", 1'b1, 1'b0, W'($urandom), 1'($urandom), 8'hEE, 1'($urandom));
        // R4: one directed bad beat, then clean beats.
        step("R4", 1'b1, 1'b0, 8'h11, 1'b0, pick_dout(1'b1), 1'b0);
        step("R4", 1'b1, 1'b0, 8'h22, 1'b0, pick_dout(1'b0), 1'b0);
        // R1: random free-running traffic with occasional corruption.
        for (int i = 0; i < 60; i++)
            step("R1", 1'b1, 1'b0, W'($urandom), 1'($urandom), pick_dout($urandom_range(0, 9) == 0), 1'($urandom));
        // R8: mode pin flips while running; behaviour stays free-running.
        for (int i = 0; i < 12; i++)
            step("R8", 1'b1, 1'b1, W'($urandom), 1'($urandom), pick_dout(1'b0), 1'($urandom));

        // Valid-qualified mode.
        do_reset(1'b1);
        // R6: output beats before LAT valid inputs are underflows.
        step("R6", 1'b1, 1'b1, 8'hA1, 1'b0, 8'h00, 1'b1);
        step("R6", 1'b1, 1'b1, 8'hA2, 1'b1, 8'h00, 1'b0);
        step("R6", 1'b1, 1'b1, 8'hA3, 1'b0, 8'h00, 1'b0);
        step("R6", 1'b1, 1'b1, 8'hA4, 1'b1, 8'h00, 1'b1);
        step("R6", 1'b1, 1'b1, 8'hA5, 1'b1, 8'h00, 1'b1);
        // R2: third valid input recorded; now a correct beat is clean (expects A2).
        step("R2", 1'b1, 1'b1, 8'hA6, 1'b0, 8'hA2, 1'b1);
        // R5: idle output cycles with junk words.
        step("R5", 1'b1, 1'b1, 8'hA7, 1'b0, 8'h5A, 1'b0);
        step("R5", 1'b1, 1'b1, 8'hA8, 1'b0, 8'hC3, 1'b0);

        // Clean reset in gated mode so the sticky flag is checked from zero again.
        do_reset(1'b1);
        for (int i = 0; i < 300; i++) begin
            bit vo;
            vo = ($urandom_range(0, 2) != 0);
            if (vo)
                step("R2", 1'b1, 1'b1, W'($urandom), ($urandom_range(0, 2) == 0),
                     pick_dout($urandom_range(0, 11) == 0), 1'b1);
            else
                step("R5", 1'b1, 1'b1, W'($urandom), ($urandom_range(0, 2) == 0), W'($urandom), 1'b0);
        end
        // R8: mode pin drops while running; gating rules still apply.
        for (int i = 0; i < 12; i++)
            step("R8", 1'b1, 1'b0, W'($urandom), 1'($urandom), W'($urandom), 1'b0);

        // Back to free-running with clean traffic.
        do_reset(1'b0);
        for (int i = 0; i < 40; i++)
            step("R1", 1'b1, 1'b0, W'($urandom), 1'b0, pick_dout(1'b0), 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule